// File: doc/BRIEF.md
# Memory Dependence Wakeup Scheduler

This block sits beside the issue logic of an out-of-order core. It holds the memory instructions that are in flight and decides when each one may issue. Each inserted load or store brings a sequence number, a PC, its kind and a flag that says whether its source registers are ready. While the insert is presented, the PC is shown to an external dependence predictor. The predictor answers in the same cycle with the sequence number of the store the instruction is expected to depend on, or zero. An instruction becomes eligible only when its registers are ready and its predicted producer store has issued.

Eligible instructions compete for a single issue slot, and the oldest one, meaning the smallest sequence number, is always presented. When the consumer pops that entry, the block reports the issue to the predictor. If the popped entry is a store, every instruction linked to it is released. A squash with a sequence number rolls back every younger entry. Non-speculative instructions are held until they are released explicitly. Ordering violations found elsewhere are passed on to the predictor. The predictor tables themselves are outside this block.

Top module: `mdw_sched`

## Requirements
- R1: After a synchronous reset the table is empty: top_valid, full and ins_err are 0, both conflict counters are 0, and every predictor notification valid is 0.
- R2: ins_kind 2'b01 is a load and 2'b10 is a store. An accepted insert whose pred_chk_prod is zero, or names a store not currently held, has no memory dependence. With ins_regs_rdy set it can be the top from the next cycle. Otherwise it waits until a regs_rdy_valid pulse carrying its sequence number, and can be the top from the cycle after that pulse.
- R3: An accepted insert whose pred_chk_prod names a held store is linked to that store. It becomes eligible only once both its registers are ready and that store has been popped. Each such link increments conf_ld_cnt (load) or conf_st_cnt (store) one cycle later.
- R4: top_valid is 1 exactly when some eligible entry exists. top_seq, top_pc and top_store then describe the eligible entry with the smallest sequence number.
- R5: A pop while top_valid is 1 removes the top entry. The next cycle carries a one-cycle pred_iss_valid pulse with its sequence number, PC and store flag. Popping a store releases its linked entries, and those whose registers are ready are eligible from the next cycle. Popping a load releases nothing.
- R6: Every accepted store insert produces a one-cycle pred_st_valid pulse carrying its PC and sequence number on the next cycle. The store stays held, and available as a producer, until it is popped or squashed.
- R7: An insert with ins_nonspec set waits whatever its register state. It becomes eligible only from the cycle after a ns_go_valid pulse carrying its sequence number.
- R8: A squash with number N removes every entry whose sequence number is greater than N, and produces a one-cycle pred_sq_valid pulse carrying N on the next cycle. In a squash cycle, insert, regs-ready, non-speculative release and pop are all ignored.
- R9: A viol_valid pulse is forwarded the next cycle as pred_viol_valid, carrying the load PC and store PC unchanged.
- R10: An accepted insert whose ins_kind is 2'b00 or 2'b11, or a store whose sequence number equals that of a held store, is not stored. Either case produces a one-cycle ins_err pulse on the next cycle.
- R11: full is 1 while all slots are occupied, and an insert presented while full is 1 is dropped with no effect.
- R12: An insert that names as its producer the store being popped in the same cycle is treated as having no memory dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_kind | input | 2 | 01 load, 10 store, other codes illegal |
| ins_regs_rdy | input | 1 | Source registers already ready |
| ins_nonspec | input | 1 | Hold until explicit non-speculative release |
| pred_chk_pc | output | PC_W | PC offered to the predictor lookup |
| pred_chk_prod | input | SEQ_W | Predicted producer store sequence number, 0 for none |
| regs_rdy_valid | input | 1 | Registers became ready for one entry |
| regs_rdy_seq | input | SEQ_W | Sequence number of that entry |
| ns_go_valid | input | 1 | Non-speculative release |
| ns_go_seq | input | SEQ_W | Sequence number being released |
| pop | input | 1 | Remove the current top entry |
| top_valid | output | 1 | An eligible entry exists |
| top_seq | output | SEQ_W | Sequence number of the oldest eligible entry |
| top_pc | output | PC_W | PC of the oldest eligible entry |
| top_store | output | 1 | Oldest eligible entry is a store |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| viol_valid | input | 1 | Ordering violation report |
| viol_ld_pc | input | PC_W | PC of the violating load |
| viol_st_pc | input | PC_W | PC of the store it overtook |
| pred_st_valid | output | 1 | Store-insert notification |
| pred_st_seq | output | SEQ_W | Sequence number of the inserted store |
| pred_st_pc | output | PC_W | PC of the inserted store |
| pred_iss_valid | output | 1 | Issue notification |
| pred_iss_seq | output | SEQ_W | Sequence number of the popped entry |
| pred_iss_pc | output | PC_W | PC of the popped entry |
| pred_iss_store | output | 1 | Popped entry was a store |
| pred_sq_valid | output | 1 | Squash notification |
| pred_sq_seq | output | SEQ_W | Forwarded squash number |
| pred_viol_valid | output | 1 | Violation notification |
| pred_viol_ld_pc | output | PC_W | Forwarded load PC |
| pred_viol_st_pc | output | PC_W | Forwarded store PC |
| full | output | 1 | All slots occupied |
| ins_err | output | 1 | Illegal kind or duplicate store on insert |
| conf_ld_cnt | output | CNT_W | Loads linked to a producer store |
| conf_st_cnt | output | CNT_W | Stores linked to a producer store |

## Verification
The embedded properties check, on every cycle, that the presented top is never younger than another eligible entry and that no entry is eligible while top_valid is low. They also check that every link points at a live store slot, that no entry above the squash number survives into the cycle after a squash, and that pops, store inserts and illegal kinds each produce their notification pulse. Only the bench scenarios can show the full ordering of events. These include an entry held first by its registers and then by its store, a non-speculative entry that ignores register readiness, an insert racing the pop of its own producer, duplicate stores, squash priority over a same-cycle insert, and drops while full. A reference model, run under long random mixes of all operations, exposes these.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_BAD   = 2'b11
  } mdw_kind_e;
endpackage

// File: rtl/mdw_cam.sv
module mdw_cam #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]        mask,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && tags[i] == key) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mdw_first.sv
module mdw_first #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mdw_pick.sv
module mdw_pick #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][W-1:0] tags,
  output logic                vld,
  output logic [IW-1:0]       idx
);
  localparam int NODES = 2 * N - 1;

  logic          nv [NODES];
  logic [W-1:0]  nk [NODES];
  logic [IW-1:0] ni [NODES];

  for (genvar l = 0; l < N; l++) begin : g_leaf
    assign nv[N-1+l] = req[l];
    assign nk[N-1+l] = tags[l];
    assign ni[N-1+l] = IW'(l);
  end

  // binary min tree: node k merges children 2k+1 and 2k+2
  for (genvar k = 0; k < N - 1; k++) begin : g_node
    logic take_l;
    assign take_l = nv[2*k+1] && (!nv[2*k+2] || nk[2*k+1] <= nk[2*k+2]);
    assign nv[k]  = nv[2*k+1] || nv[2*k+2];
    assign nk[k]  = take_l ? nk[2*k+1] : nk[2*k+2];
    assign ni[k]  = take_l ? ni[2*k+1] : ni[2*k+2];
  end

  assign vld = nv[0];
  assign idx = ni[0];
endmodule

// File: rtl/mdw_sched.sv
module mdw_sched
  import mdw_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [1:0]       ins_kind,
  input  logic             ins_regs_rdy,
  input  logic             ins_nonspec,
  output logic [PC_W-1:0]  pred_chk_pc,
  input  logic [SEQ_W-1:0] pred_chk_prod,
  input  logic             regs_rdy_valid,
  input  logic [SEQ_W-1:0] regs_rdy_seq,
  input  logic             ns_go_valid,
  input  logic [SEQ_W-1:0] ns_go_seq,
  input  logic             pop,
  output logic             top_valid,
  output logic [SEQ_W-1:0] top_seq,
  output logic [PC_W-1:0]  top_pc,
  output logic             top_store,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_ld_pc,
  input  logic [PC_W-1:0]  viol_st_pc,
  output logic             pred_st_valid,
  output logic [SEQ_W-1:0] pred_st_seq,
  output logic [PC_W-1:0]  pred_st_pc,
  output logic             pred_iss_valid,
  output logic [SEQ_W-1:0] pred_iss_seq,
  output logic [PC_W-1:0]  pred_iss_pc,
  output logic             pred_iss_store,
  output logic             pred_sq_valid,
  output logic [SEQ_W-1:0] pred_sq_seq,
  output logic             pred_viol_valid,
  output logic [PC_W-1:0]  pred_viol_ld_pc,
  output logic [PC_W-1:0]  pred_viol_st_pc,
  output logic             full,
  output logic             ins_err,
  output logic [CNT_W-1:0] conf_ld_cnt,
  output logic [CNT_W-1:0] conf_st_cnt
);
  localparam int IDX_W = $clog2(SLOTS);

  // slot table
  logic [SLOTS-1:0]             v_q, st_q, rr_q, mr_q, ns_q, hp_q;
  logic [SLOTS-1:0][SEQ_W-1:0]  seq_q;
  logic [SLOTS-1:0][IDX_W-1:0]  prod_q;
  logic [PC_W-1:0]              pc_mem [SLOTS];

  logic [SLOTS-1:0] rdy_vec;
  logic             top_hit;
  logic [IDX_W-1:0] top_idx;
  logic             p_hit, d_hit, r_hit, n_hit, f_hit;
  logic [IDX_W-1:0] p_idx, d_idx, r_idx, n_idx, f_idx;

  assign rdy_vec     = v_q & rr_q & mr_q;
  assign full        = &v_q;
  assign pred_chk_pc = ins_pc;

  mdw_pick #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_pick (
    .req(rdy_vec), .tags(seq_q), .vld(top_hit), .idx(top_idx));

  mdw_cam #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_cam_prod (
    .mask(v_q & st_q), .tags(seq_q), .key(pred_chk_prod), .hit(p_hit), .idx(p_idx));
  mdw_cam #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_cam_dup (
    .mask(v_q & st_q), .tags(seq_q), .key(ins_seq), .hit(d_hit), .idx(d_idx));
  mdw_cam #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_cam_regs (
    .mask(v_q), .tags(seq_q), .key(regs_rdy_seq), .hit(r_hit), .idx(r_idx));
  mdw_cam #(.N(SLOTS), .W(SEQ_W), .IW(IDX_W)) u_cam_ns (
    .mask(v_q & ns_q), .tags(seq_q), .key(ns_go_seq), .hit(n_hit), .idx(n_idx));

  mdw_first #(.N(SLOTS), .IW(IDX_W)) u_free (
    .bits(~v_q), .hit(f_hit), .idx(f_idx));

  assign top_valid = top_hit;
  assign top_seq   = seq_q[top_idx];
  assign top_pc    = pc_mem[top_idx];
  assign top_store = st_q[top_idx];

  // control decode
  logic do_sq, do_pop, pop_st, kind_ok, is_st, accept, bad_ins, ins_go, dep;
  logic r_go, n_go;

  assign do_sq   = squash_valid;
  assign do_pop  = pop && top_hit && !do_sq;
  assign pop_st  = do_pop && st_q[top_idx];
  assign is_st   = (ins_kind == KIND_STORE);
  assign kind_ok = (ins_kind == KIND_LOAD) || is_st;
  assign accept  = ins_valid && !full && !do_sq && f_hit;
  assign bad_ins = !kind_ok || (is_st && d_hit);
  assign ins_go  = accept && !bad_ins;
  assign dep     = !ins_nonspec && (pred_chk_prod != '0) && p_hit &&
                   !(pop_st && p_idx == top_idx);
  assign r_go    = regs_rdy_valid && r_hit && !do_sq;
  assign n_go    = ns_go_valid && n_hit && !do_sq;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= '0;
      st_q   <= '0;
      rr_q   <= '0;
      mr_q   <= '0;
      ns_q   <= '0;
      hp_q   <= '0;
      seq_q  <= '0;
      prod_q <= '0;
    end else if (do_sq) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (v_q[i] && seq_q[i] > squash_seq) v_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (pop_st && v_q[i] && hp_q[i] && prod_q[i] == top_idx) begin
          hp_q[i] <= 1'b0;
          mr_q[i] <= 1'b1;
        end
        if (r_go && r_idx == IDX_W'(i)) rr_q[i] <= 1'b1;
        if (n_go && n_idx == IDX_W'(i)) begin
          rr_q[i] <= 1'b1;
          mr_q[i] <= 1'b1;
        end
      end
      if (do_pop) v_q[top_idx] <= 1'b0;
      if (ins_go) begin
        v_q[f_idx]    <= 1'b1;
        seq_q[f_idx]  <= ins_seq;
        st_q[f_idx]   <= is_st;
        ns_q[f_idx]   <= ins_nonspec;
        hp_q[f_idx]   <= dep;
        prod_q[f_idx] <= p_idx;
        rr_q[f_idx]   <= !ins_nonspec && ins_regs_rdy;
        mr_q[f_idx]   <= !ins_nonspec && !dep;
      end
    end
  end

  // PC storage, written only on insert
  always_ff @(posedge clk) begin
    if (ins_go) pc_mem[f_idx] <= ins_pc;
  end

  // registered notifications
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_st_valid   <= 1'b0;
      pred_st_seq     <= '0;
      pred_st_pc      <= '0;
      pred_iss_valid  <= 1'b0;
      pred_iss_seq    <= '0;
      pred_iss_pc     <= '0;
      pred_iss_store  <= 1'b0;
      pred_sq_valid   <= 1'b0;
      pred_sq_seq     <= '0;
      pred_viol_valid <= 1'b0;
      pred_viol_ld_pc <= '0;
      pred_viol_st_pc <= '0;
      ins_err         <= 1'b0;
      conf_ld_cnt     <= '0;
      conf_st_cnt     <= '0;
    end else begin
      pred_st_valid   <= ins_go && is_st;
      pred_st_seq     <= ins_seq;
      pred_st_pc      <= ins_pc;
      pred_iss_valid  <= do_pop;
      pred_iss_seq    <= top_seq;
      pred_iss_pc     <= top_pc;
      pred_iss_store  <= top_store;
      pred_sq_valid   <= do_sq;
      pred_sq_seq     <= squash_seq;
      pred_viol_valid <= viol_valid;
      pred_viol_ld_pc <= viol_ld_pc;
      pred_viol_st_pc <= viol_st_pc;
      ins_err         <= accept && bad_ins;
      if (ins_go && dep) begin
        if (is_st) conf_st_cnt <= conf_st_cnt + CNT_W'(1);
        else       conf_ld_cnt <= conf_ld_cnt + CNT_W'(1);
      end
    end
  end

  // checks on table state against the pick and notification outputs
  logic older_rdy, above_sq, link_bad;
  always_comb begin
    older_rdy = 1'b0;
    above_sq  = 1'b0;
    link_bad  = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rdy_vec[i] && top_hit && seq_q[i] < top_seq) older_rdy = 1'b1;
      if (v_q[i] && seq_q[i] > pred_sq_seq) above_sq = 1'b1;
      if (v_q[i] && hp_q[i] && !(v_q[prod_q[i]] && st_q[prod_q[i]])) link_bad = 1'b1;
    end
  end

  // R4
  top_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    !older_rdy && ((rdy_vec != '0) == top_valid));

  // R3
  dep_link_chk: assert property (@(posedge clk) disable iff (rst) !link_bad);

  // R5
  pop_report_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && top_valid && !squash_valid) |=> (pred_iss_valid && pred_iss_seq == $past(top_seq)));

  // R8
  squash_clean_chk: assert property (@(posedge clk) disable iff (rst)
    pred_sq_valid |-> !above_sq);

  // R6
  store_note_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !full && !squash_valid && ins_kind == KIND_STORE && !d_hit)
      |=> (pred_st_valid && pred_st_seq == $past(ins_seq)));

  // R10
  bad_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !full && !squash_valid && !(ins_kind == KIND_LOAD || ins_kind == KIND_STORE))
      |=> ins_err);
endmodule

// File: tb/mdw_sched_tb.sv
module mdw_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 16;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic             ins_valid, ins_regs_rdy, ins_nonspec;
  logic [SEQ_W-1:0] ins_seq, pred_chk_prod, regs_rdy_seq, ns_go_seq, squash_seq;
  logic [PC_W-1:0]  ins_pc, viol_ld_pc, viol_st_pc, pred_chk_pc;
  logic [1:0]       ins_kind;
  logic             regs_rdy_valid, ns_go_valid, pop, squash_valid, viol_valid;
  logic             top_valid, top_store, full, ins_err;
  logic [SEQ_W-1:0] top_seq, pred_st_seq, pred_iss_seq, pred_sq_seq;
  logic [PC_W-1:0]  top_pc, pred_st_pc, pred_iss_pc, pred_viol_ld_pc, pred_viol_st_pc;
  logic             pred_st_valid, pred_iss_valid, pred_iss_store, pred_sq_valid, pred_viol_valid;
  logic [CNT_W-1:0] conf_ld_cnt, conf_st_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdw_sched #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc),
    .ins_kind(ins_kind), .ins_regs_rdy(ins_regs_rdy), .ins_nonspec(ins_nonspec),
    .pred_chk_pc(pred_chk_pc), .pred_chk_prod(pred_chk_prod),
    .regs_rdy_valid(regs_rdy_valid), .regs_rdy_seq(regs_rdy_seq),
    .ns_go_valid(ns_go_valid), .ns_go_seq(ns_go_seq), .pop(pop),
    .top_valid(top_valid), .top_seq(top_seq), .top_pc(top_pc), .top_store(top_store),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .pred_st_valid(pred_st_valid), .pred_st_seq(pred_st_seq), .pred_st_pc(pred_st_pc),
    .pred_iss_valid(pred_iss_valid), .pred_iss_seq(pred_iss_seq), .pred_iss_pc(pred_iss_pc),
    .pred_iss_store(pred_iss_store), .pred_sq_valid(pred_sq_valid), .pred_sq_seq(pred_sq_seq),
    .pred_viol_valid(pred_viol_valid), .pred_viol_ld_pc(pred_viol_ld_pc),
    .pred_viol_st_pc(pred_viol_st_pc), .full(full), .ins_err(ins_err),
    .conf_ld_cnt(conf_ld_cnt), .conf_st_cnt(conf_st_cnt));

  int n_chk = 0;
  int n_err = 0;

  // reference model
  bit          mv [SLOTS];
  bit          mst[SLOTS];
  bit          mrr[SLOTS];
  bit          mmr[SLOTS];
  bit          mns[SLOTS];
  int unsigned ms [SLOTS];
  int unsigned mpc[SLOTS];
  int unsigned mprod[SLOTS];
  bit e_st_v, e_iss_v, e_iss_st, e_sq_v, e_vi_v, e_err;
  int unsigned e_st_seq, e_st_pc, e_iss_seq, e_iss_pc, e_sq_seq, e_vi_ld, e_vi_st, e_cl, e_cs;

  function automatic int m_top();
    int b = -1;
    for (int i = 0; i < SLOTS; i++)
      if (mv[i] && mrr[i] && mmr[i] && (b < 0 || ms[i] < ms[b])) b = i;
    return b;
  endfunction

  function automatic int m_find(int unsigned s, bit only_st);
    for (int i = 0; i < SLOTS; i++)
      if (mv[i] && ms[i] == s && (!only_st || mst[i])) return i;
    return -1;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < SLOTS; i++) if (mv[i]) c++;
    return c;
  endfunction

  task automatic m_update();
    int t, p, r, n, d, f;
    bit is_st, bad, dp;
    e_st_v = 0; e_iss_v = 0; e_sq_v = 0; e_err = 0;
    e_vi_v = viol_valid;
    if (viol_valid) begin e_vi_ld = viol_ld_pc; e_vi_st = viol_st_pc; end
    if (squash_valid) begin
      for (int i = 0; i < SLOTS; i++) if (mv[i] && ms[i] > squash_seq) mv[i] = 0;
      e_sq_v = 1; e_sq_seq = squash_seq;
      return;
    end
    t = m_top();
    if (!pop) t = -1;
    p = (pred_chk_prod != 0) ? m_find(pred_chk_prod, 1) : -1;
    if (p >= 0 && p == t) p = -1;  // R12 race with producer pop
    d = m_find(ins_seq, 1);
    r = m_find(regs_rdy_seq, 0);
    n = m_find(ns_go_seq, 0);
    f = -1;
    for (int i = SLOTS - 1; i >= 0; i--) if (!mv[i]) f = i;
    if (t >= 0) begin
      e_iss_v = 1; e_iss_seq = ms[t]; e_iss_pc = mpc[t]; e_iss_st = mst[t];
      mv[t] = 0;
      if (mst[t])
        for (int j = 0; j < SLOTS; j++)
          if (mv[j] && mprod[j] != 0 && mprod[j] == ms[t]) begin mprod[j] = 0; mmr[j] = 1; end
    end
    if (regs_rdy_valid && r >= 0) mrr[r] = 1;
    if (ns_go_valid && n >= 0 && mns[n]) begin mrr[n] = 1; mmr[n] = 1; end
    if (ins_valid && f >= 0) begin
      is_st = (ins_kind == 2'b10);
      bad = !(ins_kind == 2'b01 || is_st) || (is_st && d >= 0);
      if (bad) e_err = 1;
      else begin
        dp = !ins_nonspec && p >= 0;
        mv[f] = 1; ms[f] = ins_seq; mpc[f] = ins_pc; mst[f] = is_st; mns[f] = ins_nonspec;
        mprod[f] = dp ? pred_chk_prod : 0;
        mrr[f] = !ins_nonspec && ins_regs_rdy;
        mmr[f] = !ins_nonspec && !dp;
        if (is_st) begin e_st_v = 1; e_st_seq = ins_seq; e_st_pc = ins_pc; end
        if (dp) begin if (is_st) e_cs++; else e_cl++; end
      end
    end
  endtask

  task automatic chkv(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int t = m_top();
    chkv("R4", "top_valid", top_valid, t >= 0);
    if (t >= 0) begin
      chkv("R4", "top_seq", top_seq, ms[t]);
      chkv("R4", "top_pc", top_pc, mpc[t]);
      chkv("R4", "top_store", top_store, mst[t]);
    end
    chkv("R11", "full", full, m_count() == SLOTS);
    chkv("R5", "pred_iss_valid", pred_iss_valid, e_iss_v);
    if (e_iss_v) begin
      chkv("R5", "pred_iss_seq", pred_iss_seq, e_iss_seq);
      chkv("R5", "pred_iss_pc", pred_iss_pc, e_iss_pc);
      chkv("R5", "pred_iss_store", pred_iss_store, e_iss_st);
    end
    chkv("R6", "pred_st_valid", pred_st_valid, e_st_v);
    if (e_st_v) begin
      chkv("R6", "pred_st_seq", pred_st_seq, e_st_seq);
      chkv("R6", "pred_st_pc", pred_st_pc, e_st_pc);
    end
    chkv("R8", "pred_sq_valid", pred_sq_valid, e_sq_v);
    if (e_sq_v) chkv("R8", "pred_sq_seq", pred_sq_seq, e_sq_seq);
    chkv("R9", "pred_viol_valid", pred_viol_valid, e_vi_v);
    if (e_vi_v) begin
      chkv("R9", "pred_viol_ld_pc", pred_viol_ld_pc, e_vi_ld);
      chkv("R9", "pred_viol_st_pc", pred_viol_st_pc, e_vi_st);
    end
    chkv("R10", "ins_err", ins_err, e_err);
    chkv("R3", "conf_ld_cnt", conf_ld_cnt, e_cl);
    chkv("R3", "conf_st_cnt", conf_st_cnt, e_cs);
  endtask

  task automatic idle();
    ins_valid = 0; ins_seq = 0; ins_pc = 0; ins_kind = 0; ins_regs_rdy = 0; ins_nonspec = 0;
    pred_chk_prod = 0; regs_rdy_valid = 0; regs_rdy_seq = 0; ns_go_valid = 0; ns_go_seq = 0;
    pop = 0; squash_valid = 0; squash_seq = 0; viol_valid = 0; viol_ld_pc = 0; viol_st_pc = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    m_update();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic put(int unsigned s, int unsigned pc, logic [1:0] k, bit rr,
                     int unsigned prod, bit nsp);
    ins_valid = 1; ins_seq = SEQ_W'(s); ins_pc = pc; ins_kind = k;
    ins_regs_rdy = rr; pred_chk_prod = SEQ_W'(prod); ins_nonspec = nsp;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned nxt;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    compare_all();
    chkv("R1", "top_valid", top_valid, 0);
    chkv("R1", "full", full, 0);
    chkv("R1", "conf_ld_cnt", conf_ld_cnt, 0);

    // R2 no dependence, ready and waiting on registers
    put(10, 'h100, 2'b01, 1, 0, 0); tick();
    chkv("R2", "ready insert top_seq", top_seq, 10);
    pop = 1; put(11, 'h104, 2'b01, 0, 0, 0); tick();
    chkv("R2", "waiting insert top_valid", top_valid, 0);
    regs_rdy_valid = 1; regs_rdy_seq = 11; tick();
    chkv("R2", "after regs top_seq", top_seq, 11);
    pop = 1; tick();

    // R3 and R5 linked load released by store pop
    put(20, 'h200, 2'b10, 1, 0, 0); tick();
    chkv("R6", "store note seq", pred_st_seq, 20);
    put(21, 'h204, 2'b01, 1, 20, 0); tick();
    chkv("R3", "linked load held, top_seq", top_seq, 20);
    chkv("R3", "conf_ld_cnt", conf_ld_cnt, 1);
    pop = 1; tick();
    chkv("R5", "dependent woken top_seq", top_seq, 21);
    chkv("R5", "pred_iss_store", pred_iss_store, 1);
    pop = 1; tick();

    // R7 non-speculative
    put(30, 'h300, 2'b01, 1, 0, 1); tick();
    chkv("R7", "held top_valid", top_valid, 0);
    regs_rdy_valid = 1; regs_rdy_seq = 30; tick();
    chkv("R7", "regs ignored top_valid", top_valid, 0);
    ns_go_valid = 1; ns_go_seq = 30; tick();
    chkv("R7", "released top_seq", top_seq, 30);
    pop = 1; tick();

    // R12 insert racing producer pop
    put(40, 'h400, 2'b10, 1, 0, 0); tick();
    pop = 1; put(41, 'h404, 2'b01, 1, 40, 0); tick();
    chkv("R12", "race top_seq", top_seq, 41);
    chkv("R12", "no conflict counted", conf_ld_cnt, 1);
    pop = 1; tick();

    // R10 illegal kind and duplicate store
    put(45, 'h450, 2'b11, 1, 0, 0); tick();
    chkv("R10", "bad kind err", ins_err, 1);
    put(50, 'h500, 2'b10, 0, 0, 0); tick();
    put(50, 'h504, 2'b10, 1, 0, 0); tick();
    chkv("R10", "duplicate store err", ins_err, 1);
    chkv("R10", "duplicate not stored", top_valid, 0);
    put(51, 'h510, 2'b01, 1, 50, 0); tick();
    chkv("R6", "store still tracked", top_valid, 0);
    squash_valid = 1; squash_seq = 49; tick();
    chkv("R8", "pred_sq_seq", pred_sq_seq, 49);
    put(52, 'h520, 2'b01, 1, 50, 0); tick();
    chkv("R2", "untracked producer top_seq", top_seq, 52);
    pop = 1; tick();

    // R8 squash beats same-cycle insert
    squash_valid = 1; squash_seq = 60; put(70, 'h700, 2'b01, 1, 0, 0); tick();
    chkv("R8", "insert ignored top_valid", top_valid, 0);

    // R11 fill and drop
    for (int k = 0; k < SLOTS; k++) begin put(100 + k, 'h1000 + k, 2'b01, 0, 0, 0); tick(); end
    chkv("R11", "full set", full, 1);
    put(200, 'h2000, 2'b01, 1, 0, 0); tick();
    chkv("R11", "dropped top_valid", top_valid, 0);
    squash_valid = 1; squash_seq = 0; tick();
    chkv("R11", "full cleared", full, 0);

    // R9 violation
    viol_valid = 1; viol_ld_pc = 'hABC0; viol_st_pc = 'hDEF0; tick();
    chkv("R9", "viol ld pc", pred_viol_ld_pc, 'hABC0);

    // random mix, checked every cycle against the model
    void'($urandom(32'd1234));
    nxt = 1000;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 25 == 0) begin
        squash_valid = 1; squash_seq = SEQ_W'(nxt - 1 - $urandom % 12);
      end
      if ($urandom % 3 != 0) begin
        int unsigned r = $urandom % 20;
        int unsigned pr = 0;
        int unsigned sel = $urandom % 4;
        logic [1:0] k = (r == 0) ? 2'b11 : (r < 9 ? 2'b01 : 2'b10);
        if (sel == 1) pr = nxt - 1 - $urandom % 8;
        else if (sel >= 2) begin
          int o = $urandom % SLOTS;
          for (int j = 0; j < SLOTS; j++)
            if (pr == 0 && mv[(j + o) % SLOTS] && mst[(j + o) % SLOTS]) pr = ms[(j + o) % SLOTS];
        end
        put(nxt, $urandom, k, $urandom % 2, pr, $urandom % 10 == 0);
        nxt++;
      end
      if ($urandom % 2 == 0) begin
        int o = $urandom % SLOTS;
        for (int j = 0; j < SLOTS; j++)
          if (!regs_rdy_valid && mv[(j + o) % SLOTS] && !mrr[(j + o) % SLOTS]) begin
            regs_rdy_valid = 1; regs_rdy_seq = SEQ_W'(ms[(j + o) % SLOTS]);
          end
      end
      if ($urandom % 4 == 0) begin
        int o = $urandom % SLOTS;
        for (int j = 0; j < SLOTS; j++)
          if (!ns_go_valid && mv[(j + o) % SLOTS] && mns[(j + o) % SLOTS]) begin
            ns_go_valid = 1; ns_go_seq = SEQ_W'(ms[(j + o) % SLOTS]);
          end
      end
      pop = ($urandom % 2 == 0);
      if ($urandom % 15 == 0) begin viol_valid = 1; viol_ld_pc = $urandom; viol_st_pc = $urandom; end
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule